// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the control unit of a multicycle 32-bit load/store processor that runs a small instruction subset: word load, word store, register-to-register arithmetic, branch-if-equal and unconditional jump. It holds one state register and sets every datapath control line from that register alone. The next state depends on the current state and the 6-bit opcode, which the datapath supplies from its instruction register.

An instruction always starts with a fetch cycle and a decode cycle. The decode cycle picks a path from the opcode. A branch or a jump finishes in three cycles, a store or an arithmetic instruction in four, and a load in five. The datapath, the ALU function decoder and the memories are outside this block.

Top module: `mc_control_fsm`

## Requirements
- R1: A synchronous active-high `rst` puts the sequencer in the fetch state. From the first clock edge with `rst` high, and for as long as it stays high, the outputs show the fetch pattern whatever the opcode is. This applies even in the middle of an instruction.
- R2: Fetch pattern: `pc_we`=1, `mem_rd`=1, `ir_we`=1, `mem_addr_sel`=0, `alu_a_sel`=0, `alu_b_sel`=01, `alu_op`=00, `pc_src`=00, and every other output 0. The next cycle is always decode.
- R3: Decode pattern: `alu_a_sel`=0, `alu_b_sel`=11, `alu_op`=00, and all other outputs 0.
- R4: After decode the sequencer goes to the address state for opcode 35 (load) or 43 (store). It goes to the execute state for opcode 0 (arithmetic), the branch state for opcode 4, and the jump state for opcode 2. Any other opcode sends it back to fetch, so that instruction takes two cycles.
- R5: Address pattern: `alu_a_sel`=1, `alu_b_sel`=10, `alu_op`=00, and all other outputs 0. The next state is the store state when the opcode is 43, and the read state otherwise.
- R6: A load passes through fetch, decode, address, read and load-writeback, which is 5 cycles. Read pattern: `mem_rd`=1 and `mem_addr_sel`=1. Load-writeback pattern: `rf_we`=1, `rf_wdata_sel`=1 and `rf_waddr_sel`=0.
- R7: A store passes through fetch, decode, address and store, which is 4 cycles. Store pattern: `mem_wr`=1 and `mem_addr_sel`=1.
- R8: An arithmetic instruction passes through fetch, decode, execute and register-writeback, which is 4 cycles. Execute pattern: `alu_a_sel`=1, `alu_b_sel`=00 and `alu_op`=10. Register-writeback pattern: `rf_we`=1, `rf_waddr_sel`=1 and `rf_wdata_sel`=0.
- R9: A branch passes through fetch, decode and branch, which is 3 cycles. Branch pattern: `pc_we_cond`=1, `alu_a_sel`=1, `alu_b_sel`=00, `alu_op`=01 and `pc_src`=01.
- R10: A jump passes through fetch, decode and jump, which is 3 cycles. Jump pattern: `pc_we`=1 and `pc_src`=10.
- R11: Outputs not named for a state are 0. The cycle after load-writeback, store, register-writeback, branch or jump is a fetch.
- R12: Memory read and memory write are never asserted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Opcode field of the held instruction |
| pc_we | output | 1 | Unconditional program counter write |
| pc_we_cond | output | 1 | Program counter write when the ALU reports equal |
| mem_addr_sel | output | 1 | Memory address source: 0 program counter, 1 ALU result register |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| ir_we | output | 1 | Instruction register load |
| rf_wdata_sel | output | 1 | Register write data: 0 ALU result, 1 memory data |
| rf_waddr_sel | output | 1 | Register write index: 0 rt field, 1 rd field |
| rf_we | output | 1 | Register file write |
| alu_a_sel | output | 1 | ALU operand A: 0 program counter, 1 register A |
| alu_b_sel | output | 2 | ALU operand B: 00 register B, 01 constant 4, 10 offset, 11 shifted offset |
| alu_op | output | 2 | ALU class: 00 add, 01 subtract, 10 from function field |
| pc_src | output | 2 | Program counter source: 00 ALU, 01 ALU result register, 10 jump target |

## Verification
The checker watches the state register on every cycle. It checks that the state stays among the ten legal codes, that fetch is always followed by decode, and that decode and address make the right choice for each opcode. It also checks that every instruction-ending pattern (register write, memory write, conditional PC write, jump) is followed by a fetch, and that memory read and write never overlap. The bench scenarios are the only place where the full control word is compared at each step. They show the exact length of each instruction class, the two-cycle return for an unknown opcode, and a reset that cuts off a load partway through.

// File: rtl/mc_ctrl_pkg.sv
package mc_ctrl_pkg;

    localparam int STATE_W  = 4;
    localparam int OPCODE_W = 6;
    localparam int SEL_W    = 2;

    localparam logic [OPCODE_W-1:0] OPC_ARITH  = 6'd0;
    localparam logic [OPCODE_W-1:0] OPC_JUMP   = 6'd2;
    localparam logic [OPCODE_W-1:0] OPC_BEQ    = 6'd4;
    localparam logic [OPCODE_W-1:0] OPC_LOAD   = 6'd35;
    localparam logic [OPCODE_W-1:0] OPC_STORE  = 6'd43;

    typedef enum logic [STATE_W-1:0] {
        ST_FETCH   = 4'd0,
        ST_DECODE  = 4'd1,
        ST_ADDR    = 4'd2,
        ST_MEMRD   = 4'd3,
        ST_LDWB    = 4'd4,
        ST_MEMWR   = 4'd5,
        ST_EXEC    = 4'd6,
        ST_RWB     = 4'd7,
        ST_BRANCH  = 4'd8,
        ST_JUMP    = 4'd9
    } state_t;

    localparam logic [STATE_W-1:0] LAST_STATE = 4'd9;

    typedef struct packed {
        logic             pc_we;
        logic             pc_we_cond;
        logic             mem_addr_sel;
        logic             mem_rd;
        logic             mem_wr;
        logic             ir_we;
        logic             rf_wdata_sel;
        logic             rf_waddr_sel;
        logic             rf_we;
        logic             alu_a_sel;
        logic [SEL_W-1:0] alu_b_sel;
        logic [SEL_W-1:0] alu_op;
        logic [SEL_W-1:0] pc_src;
    } ctrl_t;

    localparam logic [SEL_W-1:0] B_REG    = 2'b00;
    localparam logic [SEL_W-1:0] B_FOUR   = 2'b01;
    localparam logic [SEL_W-1:0] B_OFFS   = 2'b10;
    localparam logic [SEL_W-1:0] B_OFFSH  = 2'b11;
    localparam logic [SEL_W-1:0] OP_ADD   = 2'b00;
    localparam logic [SEL_W-1:0] OP_SUB   = 2'b01;
    localparam logic [SEL_W-1:0] OP_FUNCT = 2'b10;
    localparam logic [SEL_W-1:0] PCS_ALU  = 2'b00;
    localparam logic [SEL_W-1:0] PCS_OUT  = 2'b01;
    localparam logic [SEL_W-1:0] PCS_JMP  = 2'b10;

    function automatic ctrl_t ctrl_for(input state_t st);
        ctrl_t c;
        c = '0;
        case (st)
            ST_FETCH: begin
                c.mem_rd    = 1'b1;
                c.ir_we     = 1'b1;
                c.pc_we     = 1'b1;
                c.alu_b_sel = B_FOUR;
                c.alu_op    = OP_ADD;
                c.pc_src    = PCS_ALU;
            end
            ST_DECODE: begin
                c.alu_b_sel = B_OFFSH;
                c.alu_op    = OP_ADD;
            end
            ST_ADDR: begin
                c.alu_a_sel = 1'b1;
                c.alu_b_sel = B_OFFS;
                c.alu_op    = OP_ADD;
            end
            ST_MEMRD: begin
                c.mem_rd       = 1'b1;
                c.mem_addr_sel = 1'b1;
            end
            ST_LDWB: begin
                c.rf_we        = 1'b1;
                c.rf_wdata_sel = 1'b1;
            end
            ST_MEMWR: begin
                c.mem_wr       = 1'b1;
                c.mem_addr_sel = 1'b1;
            end
            ST_EXEC: begin
                c.alu_a_sel = 1'b1;
                c.alu_b_sel = B_REG;
                c.alu_op    = OP_FUNCT;
            end
            ST_RWB: begin
                c.rf_we        = 1'b1;
                c.rf_waddr_sel = 1'b1;
            end
            ST_BRANCH: begin
                c.alu_a_sel  = 1'b1;
                c.alu_b_sel  = B_REG;
                c.alu_op     = OP_SUB;
                c.pc_we_cond = 1'b1;
                c.pc_src     = PCS_OUT;
            end
            ST_JUMP: begin
                c.pc_we  = 1'b1;
                c.pc_src = PCS_JMP;
            end
            default: c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/mc_next_state.sv
module mc_next_state
    import mc_ctrl_pkg::*;
(
    input  state_t                cur,
    input  logic [OPCODE_W-1:0]   opcode,
    output state_t                nxt
);

    state_t dispatch;

    always_comb begin
        case (opcode)
            OPC_LOAD, OPC_STORE: dispatch = ST_ADDR;
            OPC_ARITH:           dispatch = ST_EXEC;
            OPC_BEQ:             dispatch = ST_BRANCH;
            OPC_JUMP:            dispatch = ST_JUMP;
            default:             dispatch = ST_FETCH;
        endcase
    end

    always_comb begin
        case (cur)
            ST_FETCH:  nxt = ST_DECODE;
            ST_DECODE: nxt = dispatch;
            ST_ADDR:   nxt = (opcode == OPC_STORE) ? ST_MEMWR : ST_MEMRD;
            ST_MEMRD:  nxt = ST_LDWB;
            ST_EXEC:   nxt = ST_RWB;
            default:   nxt = ST_FETCH;
        endcase
    end

endmodule

// File: rtl/mc_out_decode.sv
module mc_out_decode
    import mc_ctrl_pkg::*;
(
    input  state_t cur,
    output ctrl_t  ctrl
);

    always_comb ctrl = ctrl_for(cur);

endmodule

// File: rtl/mc_control_fsm.sv
module mc_control_fsm
    import mc_ctrl_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [OPCODE_W-1:0] opcode,
    output logic                pc_we,
    output logic                pc_we_cond,
    output logic                mem_addr_sel,
    output logic                mem_rd,
    output logic                mem_wr,
    output logic                ir_we,
    output logic                rf_wdata_sel,
    output logic                rf_waddr_sel,
    output logic                rf_we,
    output logic                alu_a_sel,
    output logic [SEL_W-1:0]    alu_b_sel,
    output logic [SEL_W-1:0]    alu_op,
    output logic [SEL_W-1:0]    pc_src
);

    state_t state_q;
    state_t state_d;
    ctrl_t  ctrl;

    mc_next_state u_next (
        .cur    (state_q),
        .opcode (opcode),
        .nxt    (state_d)
    );

    mc_out_decode u_out (
        .cur  (state_q),
        .ctrl (ctrl)
    );

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_FETCH;
        else     state_q <= state_d;
    end

    assign pc_we        = ctrl.pc_we;
    assign pc_we_cond   = ctrl.pc_we_cond;
    assign mem_addr_sel = ctrl.mem_addr_sel;
    assign mem_rd       = ctrl.mem_rd;
    assign mem_wr       = ctrl.mem_wr;
    assign ir_we        = ctrl.ir_we;
    assign rf_wdata_sel = ctrl.rf_wdata_sel;
    assign rf_waddr_sel = ctrl.rf_waddr_sel;
    assign rf_we        = ctrl.rf_we;
    assign alu_a_sel    = ctrl.alu_a_sel;
    assign alu_b_sel    = ctrl.alu_b_sel;
    assign alu_op       = ctrl.alu_op;
    assign pc_src       = ctrl.pc_src;

endmodule

// File: rtl/mc_control_chk.sv
module mc_control_chk
    import mc_ctrl_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic [OPCODE_W-1:0] opcode,
    input logic [STATE_W-1:0]  state,
    input logic                pc_we,
    input logic                pc_we_cond,
    input logic                mem_rd,
    input logic                mem_wr,
    input logic                ir_we,
    input logic                rf_we
);

    // R1: a reset edge always lands in fetch
    assert_reset_fetch_R1: assert property (@(posedge clk)
        $past(rst) |-> state == 4'd0);

    // R2: fetch is always followed by decode
    assert_fetch_then_decode_R2: assert property (@(posedge clk) disable iff (rst)
        (state == 4'd0) |=> (state == 4'd1));

    // R4: decode dispatch for each opcode
    assert_dispatch_mem_R4: assert property (@(posedge clk) disable iff (rst)
        (state == 4'd1 && (opcode == 6'd35 || opcode == 6'd43)) |=> state == 4'd2);
    assert_dispatch_arith_R4: assert property (@(posedge clk) disable iff (rst)
        (state == 4'd1 && opcode == 6'd0) |=> state == 4'd6);
    assert_dispatch_beq_R4: assert property (@(posedge clk) disable iff (rst)
        (state == 4'd1 && opcode == 6'd4) |=> state == 4'd8);
    assert_dispatch_jump_R4: assert property (@(posedge clk) disable iff (rst)
        (state == 4'd1 && opcode == 6'd2) |=> state == 4'd9);

    // R5: address state picks store for opcode 43
    assert_addr_store_R5: assert property (@(posedge clk) disable iff (rst)
        (state == 4'd2 && opcode == 6'd43) |=> state == 4'd5);

    // R6: the load writeback state is reached only from the read state
    assert_load_order_R6: assert property (@(posedge clk) disable iff (rst)
        (state == 4'd4) |-> $past(state) == 4'd3);

    // R11: every instruction-ending action is followed by a fetch
    assert_end_returns_R11: assert property (@(posedge clk) disable iff (rst)
        (rf_we || mem_wr || pc_we_cond || (pc_we && !ir_we)) |=> (ir_we && mem_rd));

    // R12: read and write never overlap
    assert_no_rd_wr_R12: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    // R11: state stays among the legal codes
    assert_legal_state_R11: assert property (@(posedge clk) disable iff (rst)
        state <= LAST_STATE);

endmodule

bind mc_control_fsm mc_control_chk i_chk (
    .clk        (clk),
    .rst        (rst),
    .opcode     (opcode),
    .state      (state_q),
    .pc_we      (pc_we),
    .pc_we_cond (pc_we_cond),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr),
    .ir_we      (ir_we),
    .rf_we      (rf_we)
);

// File: tb/test_mc_control_fsm.sv
module test_mc_control_fsm;

    localparam logic [15:0] W_FETCH  = 16'h9410;
    localparam logic [15:0] W_DECODE = 16'h0030;
    localparam logic [15:0] W_ADDR   = 16'h0060;
    localparam logic [15:0] W_MEMRD  = 16'h3000;
    localparam logic [15:0] W_LDWB   = 16'h0280;
    localparam logic [15:0] W_MEMWR  = 16'h2800;
    localparam logic [15:0] W_EXEC   = 16'h0048;
    localparam logic [15:0] W_RWB    = 16'h0180;
    localparam logic [15:0] W_BRANCH = 16'h4045;
    localparam logic [15:0] W_JUMP   = 16'h8002;

    typedef struct packed {
        logic [5:0]        op;
        logic [2:0]        len;
        logic [0:4][15:0]  seq;
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VECS [0:NVEC-1] = '{
        '{6'd35, 3'd5, {W_FETCH, W_DECODE, W_ADDR, W_MEMRD, W_LDWB}},
        '{6'd43, 3'd4, {W_FETCH, W_DECODE, W_ADDR, W_MEMWR, 16'h0}},
        '{6'd0,  3'd4, {W_FETCH, W_DECODE, W_EXEC, W_RWB, 16'h0}},
        '{6'd4,  3'd3, {W_FETCH, W_DECODE, W_BRANCH, 16'h0, 16'h0}},
        '{6'd2,  3'd3, {W_FETCH, W_DECODE, W_JUMP, 16'h0, 16'h0}},
        '{6'd63, 3'd2, {W_FETCH, W_DECODE, 16'h0, 16'h0, 16'h0}},
        '{6'd35, 3'd5, {W_FETCH, W_DECODE, W_ADDR, W_MEMRD, W_LDWB}}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] opcode = 6'd0;
    logic       pc_we, pc_we_cond, mem_addr_sel, mem_rd, mem_wr, ir_we;
    logic       rf_wdata_sel, rf_waddr_sel, rf_we, alu_a_sel;
    logic [1:0] alu_b_sel, alu_op, pc_src;
    logic [15:0] word;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    mc_control_fsm i_mc_control_fsm (
        .clk          (clk),
        .rst          (rst),
        .opcode       (opcode),
        .pc_we        (pc_we),
        .pc_we_cond   (pc_we_cond),
        .mem_addr_sel (mem_addr_sel),
        .mem_rd       (mem_rd),
        .mem_wr       (mem_wr),
        .ir_we        (ir_we),
        .rf_wdata_sel (rf_wdata_sel),
        .rf_waddr_sel (rf_waddr_sel),
        .rf_we        (rf_we),
        .alu_a_sel    (alu_a_sel),
        .alu_b_sel    (alu_b_sel),
        .alu_op       (alu_op),
        .pc_src       (pc_src)
    );

    assign word = {pc_we, pc_we_cond, mem_addr_sel, mem_rd, mem_wr, ir_we,
                   rf_wdata_sel, rf_waddr_sel, rf_we, alu_a_sel,
                   alu_b_sel, alu_op, pc_src};

    task automatic check_word(input logic [15:0] exp, input string req);
        n_checks++;
        if (word !== exp) begin
            n_fail++;
            $display("FAIL %s: control word %h expected %h", req, word, exp);
        end
    endtask

    // walk one instruction, checking each cycle at the falling edge
    task automatic run_vec(input vec_t v);
        opcode = v.op;
        for (int k = 0; k < int'(v.len); k++) begin
            check_word(v.seq[k], "R4/R6/R7/R8/R9/R10 sequence");
            if (mem_rd && mem_wr) begin
                n_fail++;
                $display("FAIL R12: rd=%b wr=%b expected not both", mem_rd, mem_wr);
            end
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        check_word(W_FETCH, "R1 reset state");
        opcode = 6'd35;
        @(negedge clk);
        check_word(W_FETCH, "R1 reset held, opcode ignored");
        rst = 1'b0;

        for (int i = 0; i < NVEC; i++) run_vec(VECS[i]);
        check_word(W_FETCH, "R11 return to fetch after load");

        // R2/R3 back-to-back short instructions
        run_vec(VECS[3]);
        run_vec(VECS[4]);
        check_word(W_FETCH, "R11 return to fetch after jump");

        // R5: any non-store opcode in the address state goes to read
        opcode = 6'd43;
        @(negedge clk);
        @(negedge clk);
        check_word(W_ADDR, "R5 address state");
        opcode = 6'd0;
        @(negedge clk);
        check_word(W_MEMRD, "R5 non-store opcode selects read");
        @(negedge clk);
        check_word(W_LDWB, "R6 writeback after read");
        @(negedge clk);

        // R1: reset in the middle of a load
        opcode = 6'd35;
        @(negedge clk);
        @(negedge clk);
        check_word(W_ADDR, "R1 pre-reset address state");
        rst = 1'b1;
        @(negedge clk);
        check_word(W_FETCH, "R1 mid-instruction reset");
        rst = 1'b0;
        @(negedge clk);
        check_word(W_DECODE, "R2 decode after reset fetch");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: cycles %0d expected completion", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule